// File: doc/BRIEF.md
# SPI Port with Direction-Gated Pins

This block is an 8-bit serial peripheral port. It can run as bus master or as a selected slave. Its four pins are shared with a general-purpose port: MISO, MOSI, SCK and an active-low select. In master mode, a host write to the data register loads the shifter and starts a transfer. SCK is produced from the system clock by a fixed even divide. In slave mode, the select, clock and data pins are brought into the system clock domain through synchronizers, and the byte the host wrote earlier is shifted out while the incoming byte is shifted in. Bits move most significant first. Clock polarity and phase are set by configuration inputs.

A pin that the SPI function would drive is enabled only when its direction bit is 1. With the bit at 0 the pad is released and its level reads back on the general-purpose input vector. A pin that the SPI function uses as an input is never driven, whatever its direction bit. When a byte completes, a sticky flag rises and the received byte is latched into a read buffer. The flag clears only after a status read followed by a data access.

Top module: `spi_pinmux_port`

## Requirements
- R1: In master mode, a host write while idle starts a transfer that shifts the written byte out on MOSI (pin index 1), most significant bit first, eight bits.
- R2: In master mode, the eight bits sampled on MISO (pin index 0) appear on rx_data, first bit in the top position, in the cycle the flag rises.
- R3: Master SCK (pin index 2) rests at the cfg_cpol level when idle, toggles sixteen times per byte with SCK_DIV/2 system clocks per half period, and is back at the cfg_cpol level when the transfer ends.
- R4: With cfg_cpha=0, the first data bit is valid as soon as the transfer starts and data are sampled on odd-numbered SCK edges. With cfg_cpha=1, data change on odd edges and are sampled on even edges. All four polarity/phase combinations work.
- R5: xfer_busy is 1 from the cycle after the starting write until the last SCK edge. The flag xfer_done rises in the cycle xfer_busy falls.
- R6: xfer_done stays 1 until the host pulses host_rd_stat while it is set and afterwards pulses host_rd_data or host_wr. A data access without that prior status read leaves it set.
- R7: A pin is driven (pad_oe bit 1) only if its dir_bits bit is 1. In master mode, MOSI, SCK and select (pin index 3, driven low during a transfer) are the driven pins. gp_in always mirrors pad_i.
- R8: Pins used as SPI inputs are never driven: MISO in master mode, and MOSI, SCK and select in slave mode.
- R9: In slave mode, MISO is driven only while the synchronized select is low (and its direction bit is 1).
- R10: In slave mode, a complete select-low byte in any of the four modes shifts the previously written byte out on MISO and delivers the MOSI byte on rx_data with the flag set.
- R11: In slave mode, select returning high before the eighth bit abandons the byte: the flag does not rise, xfer_busy falls, and the next full byte is received correctly.
- R12: A host write while a master transfer is in progress is ignored and does not change the byte being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 selects master mode, 0 slave mode |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase select |
| dir_bits | input | 4 | Per-pin direction bits, 1 = output allowed (index 0 MISO, 1 MOSI, 2 SCK, 3 select) |
| host_wr | input | 1 | One-cycle data register write strobe |
| host_wdata | input | DATA_W | Data register write value |
| host_rd_data | input | 1 | One-cycle data register read strobe |
| host_rd_stat | input | 1 | One-cycle status register read strobe |
| rx_data | output | DATA_W | Last received byte |
| xfer_done | output | 1 | Sticky completion flag |
| xfer_busy | output | 1 | Byte in progress |
| pad_i | input | 4 | Pad input levels |
| pad_o | output | 4 | Pad output levels |
| pad_oe | output | 4 | Pad output enables |
| gp_in | output | 4 | General-purpose read of the pads |

## Verification
The bench plays the far end of the link in both roles. It uses a bit-level model that shifts and samples on the edge that each phase setting calls for, so a design that sampled on the wrong edge or skipped the first-bit preload would lose or rotate a bit. It cuts a slave byte short by raising select mid-byte and then checks that the next byte is still received cleanly: a design that flagged partial bytes or kept a stale bit count would fail here. It writes the data register in the middle of a master byte to catch a shifter that reloads. It also checks that the flag survives a bare data read. The output enables are checked for every mode, select state and direction setting, so a design that drove an input pin, or a released pin, or drove MISO while deselected, is caught.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
   localparam int NUM_PINS = 4;
   localparam int PIN_MISO = 0;
   localparam int PIN_MOSI = 1;
   localparam int PIN_SCK  = 2;
   localparam int PIN_SEL  = 3;

   localparam int SYNC_W    = 3;
   localparam int SYNC_MOSI = 0;
   localparam int SYNC_SCK  = 1;
   localparam int SYNC_SEL  = 2;

   typedef logic [NUM_PINS-1:0] pin_vec_t;
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
   parameter int SCK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic cpol_i,
   output logic sck_o,
   output logic tick_o
);
   localparam int HALF = SCK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   generate
      if (SCK_DIV < 2 || (SCK_DIV % 2) != 0) begin : g_bad_div
         $error("spi_sck_gen: SCK_DIV must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] div_q;

   assign tick_o = run_i && (div_q == CW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         sck_o <= 1'b0;
      end else if (!run_i) begin
         div_q <= '0;
         sck_o <= cpol_i;
      end else if (tick_o) begin
         div_q <= '0;
         sck_o <= ~sck_o;
      end else begin
         div_q <= div_q + CW'(1);
      end
   end

   AST_SCK_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_i) |-> (sck_o == cpol_i)) else $error("sck not at idle level after byte"); // R3
endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int         W       = 3,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cpha_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         abort_i,
   input  logic         step_i,
   input  logic         in_bit_i,
   output logic         out_bit_o,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] word_o
);
   localparam int NEDGE = 2 * W;
   localparam int CW    = $clog2(NEDGE);
   localparam logic [CW-1:0] LAST_EDGE = CW'(NEDGE - 1);

   logic [W-1:0]  tx_q, rx_q;
   logic [CW-1:0] cnt_q;
   logic          act_q;
   logic          lead, last;
   logic [W-1:0]  rx_next;

   assign lead      = ~cnt_q[0];
   assign last      = (cnt_q == LAST_EDGE);
   assign rx_next   = {rx_q[W-2:0], in_bit_i};
   assign out_bit_o = tx_q[W-1];
   assign busy_o    = act_q;
   assign done_o    = act_q && step_i && last && !load_i && !abort_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         rx_q   <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
         word_o <= '0;
      end else if (load_i) begin
         tx_q  <= load_val_i;
         rx_q  <= '0;
         cnt_q <= '0;
         act_q <= 1'b1;
      end else if (abort_i) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (act_q && step_i) begin
         cnt_q <= cnt_q + CW'(1);
         if (lead) begin
            if (!cpha_i)             rx_q <= rx_next;
            else if (cnt_q != '0)    tx_q <= tx_q << 1;
         end else begin
            if (cpha_i)              rx_q <= rx_next;
            else if (!last)          tx_q <= tx_q << 1;
         end
         if (last) begin
            act_q  <= 1'b0;
            word_o <= cpha_i ? rx_next : rx_q;
         end
      end
   end

   AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !step_i && !load_i) |=> $stable(tx_q)) else $error("shifter moved without an edge"); // R12
endmodule

// File: rtl/spi_pin_steer.sv
module spi_pin_steer
   import spi_port_pkg::*;
(
   input  logic     master_i,
   input  pin_vec_t dir_i,
   input  logic     slv_sel_i,
   input  logic     m_mosi_i,
   input  logic     m_sck_i,
   input  logic     m_sel_n_i,
   input  logic     s_miso_i,
   output pin_vec_t pad_o,
   output pin_vec_t pad_oe
);
   pin_vec_t want, val;

   always_comb begin
      want            = '0;
      val             = '0;
      want[PIN_MISO]  = !master_i && slv_sel_i;
      want[PIN_MOSI]  = master_i;
      want[PIN_SCK]   = master_i;
      want[PIN_SEL]   = master_i;
      val[PIN_MISO]   = s_miso_i;
      val[PIN_MOSI]   = m_mosi_i;
      val[PIN_SCK]    = m_sck_i;
      val[PIN_SEL]    = m_sel_n_i;
   end

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         assign pad_oe[p] = want[p] & dir_i[p];
         assign pad_o[p]  = pad_oe[p] ? val[p] : 1'b0;
      end
   endgenerate
endmodule

// File: rtl/spi_pinmux_port.sv
module spi_pinmux_port
   import spi_port_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SCK_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [3:0]        dir_bits,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd_data,
   input  logic              host_rd_stat,
   output logic [DATA_W-1:0] rx_data,
   output logic              xfer_done,
   output logic              xfer_busy,
   input  logic [3:0]        pad_i,
   output logic [3:0]        pad_o,
   output logic [3:0]        pad_oe,
   output logic [3:0]        gp_in
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_pinmux_port: DATA_W must be at least 2");
      end
   endgenerate

   // slave-side synchronizers (select resets high = deselected)
   logic [SYNC_W-1:0] s_q;
   logic              sck_d_q, sel_d_q;
   logic              sel_s_n, sel_rise, sel_fall, sck_evt;

   spi_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({pad_i[PIN_SEL], pad_i[PIN_SCK], pad_i[PIN_MOSI]}),
      .q_o   (s_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d_q <= 1'b0;
         sel_d_q <= 1'b1;
      end else begin
         sck_d_q <= s_q[SYNC_SCK];
         sel_d_q <= s_q[SYNC_SEL];
      end
   end

   assign sel_s_n  = s_q[SYNC_SEL];
   assign sel_rise = sel_s_n & ~sel_d_q;
   assign sel_fall = ~sel_s_n & sel_d_q;
   assign sck_evt  = s_q[SYNC_SCK] ^ sck_d_q;

   // shifter control
   logic              core_busy, core_done, core_out;
   logic              gen_tick, gen_sck;
   logic              mst_start, slv_start, core_load, core_abort, core_step;
   logic [DATA_W-1:0] tx_hold_q, load_val;

   assign mst_start  = cfg_master && host_wr && !core_busy;
   assign slv_start  = !cfg_master && sel_fall;
   assign core_load  = mst_start || slv_start;
   assign load_val   = mst_start ? host_wdata : tx_hold_q;
   assign core_abort = !cfg_master && sel_rise && core_busy;
   assign core_step  = cfg_master ? gen_tick : (sck_evt && !sel_s_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   tx_hold_q <= '0;
      else if (host_wr && !(cfg_master && core_busy)) tx_hold_q <= host_wdata;
   end

   spi_sck_gen #(.SCK_DIV(SCK_DIV)) u_sck (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (cfg_master && core_busy),
      .cpol_i (cfg_cpol),
      .sck_o  (gen_sck),
      .tick_o (gen_tick)
   );

   spi_shift_core #(.W(DATA_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpha_i     (cfg_cpha),
      .load_i     (core_load),
      .load_val_i (load_val),
      .abort_i    (core_abort),
      .step_i     (core_step),
      .in_bit_i   (cfg_master ? pad_i[PIN_MISO] : s_q[SYNC_MOSI]),
      .out_bit_o  (core_out),
      .busy_o     (core_busy),
      .done_o     (core_done),
      .word_o     (rx_data)
   );

   // completion flag: set on byte end, cleared by status read then data access
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_done <= 1'b0;
         armed_q   <= 1'b0;
      end else if (core_done) begin
         xfer_done <= 1'b1;
         armed_q   <= 1'b0;
      end else if (armed_q && (host_wr || host_rd_data)) begin
         xfer_done <= 1'b0;
         armed_q   <= 1'b0;
      end else if (host_rd_stat && xfer_done) begin
         armed_q   <= 1'b1;
      end
   end

   assign xfer_busy = core_busy;
   assign gp_in     = pad_i;

   spi_pin_steer u_steer (
      .master_i  (cfg_master),
      .dir_i     (dir_bits),
      .slv_sel_i (!sel_s_n),
      .m_mosi_i  (core_out),
      .m_sck_i   (gen_sck),
      .m_sel_n_i (!core_busy),
      .s_miso_i  (core_out),
      .pad_o     (pad_o),
      .pad_oe    (pad_oe)
   );

   AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_done) |-> !xfer_busy) else $error("flag rose mid-byte"); // R5
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !armed_q) |=> xfer_done) else $error("flag cleared without status read"); // R6
   AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~dir_bits) == 4'b0000) else $error("pin driven with direction bit clear"); // R7
   AST_INPUTS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_master ? !pad_oe[PIN_MISO] : (pad_oe[PIN_SEL:PIN_MOSI] == 3'b000)) else $error("SPI input pin driven"); // R8
   AST_UNSEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_master && sel_s_n) |-> !pad_oe[PIN_MISO]) else $error("MISO driven while deselected"); // R9
   AST_ABORT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      core_abort |=> !$rose(xfer_done)) else $error("aborted byte raised flag"); // R11
   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && core_busy && host_wr && !core_done) |=> core_busy) else $error("write restarted master byte"); // R12
endmodule

// File: tb/spi_pinmux_port_bench.sv
module spi_pinmux_port_bench;
   import spi_port_pkg::*;

   localparam int H = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, cfg_master, cfg_cpol, cfg_cpha;
   logic [3:0] dir_bits;
   logic       host_wr, host_rd_data, host_rd_stat;
   logic [7:0] host_wdata, rx_data;
   logic       xfer_done, xfer_busy;
   logic [3:0] pad_o, pad_oe, gp_in;
   logic       tb_miso, tb_mosi, tb_sck, tb_ss;
   logic [3:0] pad_i;
   assign pad_i = {tb_ss, tb_sck, tb_mosi, tb_miso};

   int n_chk = 0;
   int n_fail = 0;

   spi_pinmux_port u_spi_pinmux_port (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .dir_bits(dir_bits), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd_data(host_rd_data), .host_rd_stat(host_rd_stat), .rx_data(rx_data),
      .xfer_done(xfer_done), .xfer_busy(xfer_busy), .pad_i(pad_i), .pad_o(pad_o),
      .pad_oe(pad_oe), .gp_in(gp_in)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_oe(input logic m, input logic [3:0] d, input logic sel);
      return (m ? 4'b1110 : {3'b000, sel}) & d;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_flag();
      host_rd_stat = 1'b1; @(negedge clk); host_rd_stat = 1'b0;
      host_rd_data = 1'b1; @(negedge clk); host_rd_data = 1'b0;
   endtask

   task automatic master_xfer(input logic cpol, input logic cpha,
                              input logic [7:0] tx, input logic [7:0] sb, input logic poke);
      logic [7:0] bs_tx, bs_rx;
      logic       prev;
      int         edges, n;
      clear_flag();
      cfg_master = 1'b1; cfg_cpol = cpol; cfg_cpha = cpha; dir_bits = 4'b1110; tb_ss = 1'b1;
      idle(3);
      chk("R3 sck idle level", 32'(pad_o[PIN_SCK]), 32'(cpol));
      bs_tx = sb; bs_rx = '0; prev = cpol; edges = 0; n = 0;
      tb_miso = sb[7];
      host_wdata = tx; host_wr = 1'b1; @(negedge clk); host_wr = 1'b0;
      chk("R5 busy after write", 32'(xfer_busy), 32'd1);
      chk("R4 first bit preloaded", 32'(pad_o[PIN_MOSI]), 32'(tx[7]));
      chk("R7 select driven low", 32'(pad_o[PIN_SEL]), 32'd0);
      forever begin
         if (pad_o[PIN_SCK] !== prev) begin
            if (edges % 2 == 0) begin
               if (!cpha) bs_rx = {bs_rx[6:0], pad_o[PIN_MOSI]};
               else if (edges != 0) bs_tx = bs_tx << 1;
            end else begin
               if (cpha) bs_rx = {bs_rx[6:0], pad_o[PIN_MOSI]};
               else if (edges != 15) bs_tx = bs_tx << 1;
            end
            edges++;
            prev = pad_o[PIN_SCK];
            tb_miso = bs_tx[7];
         end
         if (xfer_done || n > 400) break;
         if (poke && n == 5) begin host_wdata = ~tx; host_wr = 1'b1; end
         else host_wr = 1'b0;
         @(negedge clk);
         n++;
      end
      host_wr = 1'b0;
      chk(poke ? "R12 busy write ignored, mosi byte" : "R1 mosi byte", 32'(bs_rx), 32'(tx));
      chk("R2 received byte", 32'(rx_data), 32'(sb));
      chk("R3 sixteen sck edges", 32'(edges), 32'd16);
      chk("R3 sck parked", 32'(pad_o[PIN_SCK]), 32'(cpol));
      chk("R5 flag set", 32'(xfer_done), 32'd1);
      chk("R5 busy cleared", 32'(xfer_busy), 32'd0);
   endtask

   task automatic slave_xfer(input logic cpol, input logic cpha,
                             input logic [7:0] hold, input logic [7:0] mb, input int abort_at);
      logic [7:0] rec;
      clear_flag();
      cfg_master = 1'b0; cfg_cpol = cpol; cfg_cpha = cpha; dir_bits = 4'b1111;
      tb_ss = 1'b1; tb_sck = cpol; tb_mosi = 1'b0;
      host_wdata = hold; host_wr = 1'b1; @(negedge clk); host_wr = 1'b0;
      idle(6);
      chk("R9 deselected slave releases MISO", 32'(pad_oe), 32'(exp_oe(1'b0, dir_bits, 1'b0)));
      tb_ss = 1'b0;
      if (!cpha) tb_mosi = mb[7];
      idle(H);
      chk("R8 selected slave drives only MISO", 32'(pad_oe), 32'(exp_oe(1'b0, dir_bits, 1'b1)));
      rec = '0;
      for (int i = 0; i < 8; i++) begin
         if (i == abort_at) break;
         if (!cpha) rec = {rec[6:0], pad_o[PIN_MISO]};
         else tb_mosi = mb[7-i];
         tb_sck = ~cpol; idle(H);
         if (cpha) rec = {rec[6:0], pad_o[PIN_MISO]};
         tb_sck = cpol;
         if (!cpha && i < 7) tb_mosi = mb[6-i];
         idle(H);
      end
      if (abort_at < 8) begin
         tb_ss = 1'b1; idle(H);
         chk("R11 aborted byte leaves flag clear", 32'(xfer_done), 32'd0);
         chk("R11 aborted byte ends busy", 32'(xfer_busy), 32'd0);
      end else begin
         chk("R10 slave flag set", 32'(xfer_done), 32'd1);
         chk("R10 slave received byte", 32'(rx_data), 32'(mb));
         chk("R10 slave sent byte", 32'(rec), 32'(hold));
         tb_ss = 1'b1; idle(H);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0C11));
      rst_n = 1'b0; cfg_master = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b0; dir_bits = 4'b0000;
      host_wr = 1'b0; host_rd_data = 1'b0; host_rd_stat = 1'b0; host_wdata = '0;
      tb_miso = 1'b0; tb_mosi = 1'b0; tb_sck = 1'b0; tb_ss = 1'b1;
      idle(4); rst_n = 1'b1; idle(3);

      chk("R5 reset flag", 32'(xfer_done), 32'd0);
      chk("R5 reset busy", 32'(xfer_busy), 32'd0);
      chk("R2 reset rx_data", 32'(rx_data), 32'd0);
      chk("R7 released with dir clear", 32'(pad_oe), 32'(exp_oe(1'b1, 4'b0000, 1'b0)));
      dir_bits = 4'b1111; idle(1);
      chk("R8 master leaves MISO input", 32'(pad_oe), 32'(exp_oe(1'b1, 4'b1111, 1'b0)));
      dir_bits = 4'b0100; tb_miso = 1'b1; tb_mosi = 1'b1; idle(1);
      chk("R7 only SCK enabled", 32'(pad_oe), 32'(exp_oe(1'b1, 4'b0100, 1'b0)));
      chk("R7 gp_in reads pads", 32'(gp_in), 32'(pad_i));

      master_xfer(1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0);
      master_xfer(1'b0, 1'b1, 8'h81, 8'h7E, 1'b0);
      master_xfer(1'b1, 1'b0, 8'h00, 8'hFF, 1'b0);
      master_xfer(1'b1, 1'b1, 8'hFF, 8'h01, 1'b0);
      master_xfer(1'b0, 1'b0, 8'h5A, 8'hC3, 1'b1);

      host_rd_data = 1'b1; @(negedge clk); host_rd_data = 1'b0;
      chk("R6 data read alone keeps flag", 32'(xfer_done), 32'd1);
      host_rd_stat = 1'b1; @(negedge clk); host_rd_stat = 1'b0;
      chk("R6 status read alone keeps flag", 32'(xfer_done), 32'd1);
      host_rd_data = 1'b1; @(negedge clk); host_rd_data = 1'b0;
      chk("R6 status then data clears flag", 32'(xfer_done), 32'd0);

      for (int k = 0; k < 10; k++) begin
         logic [7:0] a, b;
         logic [1:0] md;
         a = 8'($urandom); b = 8'($urandom); md = 2'($urandom);
         master_xfer(md[1], md[0], a, b, 1'b0);
      end

      slave_xfer(1'b0, 1'b0, 8'hC5, 8'h96, 8);
      slave_xfer(1'b0, 1'b1, 8'h0F, 8'hF0, 8);
      slave_xfer(1'b1, 1'b0, 8'h80, 8'h01, 8);
      slave_xfer(1'b1, 1'b1, 8'h7F, 8'hFE, 8);
      slave_xfer(1'b0, 1'b0, 8'hAA, 8'h55, 3);
      slave_xfer(1'b0, 1'b0, 8'h33, 8'hE1, 8);
      slave_xfer(1'b1, 1'b1, 8'h44, 8'h22, 6);
      slave_xfer(1'b1, 1'b1, 8'h9C, 8'h6B, 8);

      dir_bits = 4'b1110; tb_ss = 1'b0; idle(H);
      chk("R7 slave MISO released with dir clear", 32'(pad_oe), 32'(exp_oe(1'b0, 4'b1110, 1'b1)));
      tb_ss = 1'b1; idle(H);

      for (int k = 0; k < 6; k++) begin
         logic [7:0] a, b;
         logic [1:0] md;
         a = 8'($urandom); b = 8'($urandom); md = 2'($urandom);
         slave_xfer(md[1], md[0], a, b, 8);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule